// File: doc/BRIEF.md
# FIR Multiply-Accumulate Engine with Ring-Buffer Addressing

This block computes one output of an N-tap FIR filter each time it is told to start. Incoming samples are written into a small window memory organised as a ring: each accepted sample goes to the current head slot and the head then steps forward modulo N. No stored sample is ever moved. The coefficients sit in a second small memory that is loaded through a simple write port.

A start command costs one cycle to set up the address pointers and fetch the first operand pair. The engine then runs N multiply-accumulate steps, one per cycle, with no gaps. In every step the pointers are updated and the loop counter is tested in the same cycle as the MAC. Each product is rescaled to the fixed-point format of the samples before it is added in. The accumulator carries guard bits, so it never overflows during the sum. Saturation is applied only once, when the result is written to the output register.

Top module: `fir_mac_engine`

## Requirements
- R1: After reset `busy` and `out_valid` are 0, `out_data` is 0, and every window and coefficient entry is 0, so a filter run before any load yields 0.
- R2: `coef_we` while idle stores `coef_data` as coefficient number `coef_addr`. Coefficient 0 weights the newest sample. A coefficient write while `busy` is 1 is ignored.
- R3: `smp_valid` while idle stores `smp_data` at the head slot and advances the head modulo N. A sample offered while `busy` is 1 is ignored.
- R4: `start` while idle makes `busy` 1 on the next cycle. A `start` while `busy` is 1 is ignored and produces no extra result.
- R5: The result is the saturated value of the sum over k = 0..N-1 of floor(c[k]·x[k] / 2^FRAC). Here x[0] is the newest accepted sample, x[k] is the k-th older sample, and all values are two's complement. No saturation is applied to partial sums.
- R6: `out_valid` is a one-cycle pulse. It goes high N+2 rising edges after the start command, counting the edge that captures `start`: one setup edge plus N MAC edges. `busy` falls on that same edge.
- R7: A sum above 2^(DW-1)-1 is output as 2^(DW-1)-1. A sum below -2^(DW-1) is output as -2^(DW-1).
- R8: `out_data` keeps its value between results.
- R9: The accumulator is cleared at every start, so two runs over the same data give the same result.
- R10: Only the N newest accepted samples take part in the sum. Older ones are overwritten as the head wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | Offer a new input sample |
| smp_data | input | DW | Input sample, two's complement |
| coef_we | input | 1 | Coefficient write strobe |
| coef_addr | input | clog2(N) | Coefficient index, 0 weights the newest sample |
| coef_data | input | CW | Coefficient value, two's complement with FRAC fraction bits |
| start | input | 1 | Begin one output computation |
| busy | output | 1 | Computation in progress |
| out_valid | output | 1 | One-cycle result strobe |
| out_data | output | DW | Saturated result, held until the next one |

## Verification
The properties assume that `start`, `smp_valid` and `coef_we` are synchronous pulses sampled on rising edges, and that N is larger than one, so that an accepted sample always moves the head. They also assume that `coef_addr` stays below N whenever a write is issued. The bench changes every input on the falling clock edge and holds each strobe for exactly one rising edge. With the default power-of-two N, every address it drives is in range. It deliberately raises all three strobes during a busy interval to exercise the ignore rules.

// File: rtl/fir_mac_pkg.sv
`timescale 1ns/1ps
package fir_mac_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_LOAD = 2'd1,
    SEQ_RUN  = 2'd2
  } seq_state_t;

  // next slot of a ring of n entries
  function automatic int unsigned ring_next(input int unsigned p, input int unsigned n);
    return (p + 1 >= n) ? 0 : p + 1;
  endfunction

  // previous slot of a ring of n entries
  function automatic int unsigned ring_prev(input int unsigned p, input int unsigned n);
    return (p == 0) ? n - 1 : p - 1;
  endfunction

endpackage

// File: rtl/fir_agu.sv
`timescale 1ns/1ps
module fir_agu #(
  parameter int N  = 8,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_push,
  input  logic          load_en,
  input  logic          mac_en,
  output logic [AW-1:0] head,
  output logic [AW-1:0] newest,
  output logic [AW-1:0] sptr,
  output logic [AW-1:0] cptr
);
  import fir_mac_pkg::*;

  assign newest = AW'(ring_prev(32'(head), N));

  // write head: one step per accepted sample
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head <= '0;
    end else if (smp_push) begin
      head <= AW'(ring_next(32'(head), N));
    end
  end

  // read pointers: set in the setup cycle, stepped alongside each MAC
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sptr <= '0;
      cptr <= '0;
    end else if (load_en) begin
      sptr <= AW'(ring_prev(32'(newest), N));
      cptr <= AW'(ring_next(0, N));
    end else if (mac_en) begin
      sptr <= AW'(ring_prev(32'(sptr), N));
      cptr <= AW'(ring_next(32'(cptr), N));
    end
  end

endmodule

// File: rtl/fir_seq.sv
`timescale 1ns/1ps
module fir_seq #(
  parameter int N  = 8,
  parameter int AW = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic load_en,
  output logic mac_en,
  output logic last_tap
);
  import fir_mac_pkg::*;

  seq_state_t    state;
  logic [AW-1:0] taps_left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= SEQ_IDLE;
      taps_left <= '0;
    end else begin
      unique case (state)
        SEQ_IDLE: if (start) state <= SEQ_LOAD;
        SEQ_LOAD: begin
          taps_left <= AW'(N - 1);
          state     <= SEQ_RUN;
        end
        SEQ_RUN: begin
          if (taps_left == '0) state <= SEQ_IDLE;
          else                 taps_left <= taps_left - 1'b1;
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end

  assign busy     = (state != SEQ_IDLE);
  assign load_en  = (state == SEQ_LOAD);
  assign mac_en   = (state == SEQ_RUN);
  assign last_tap = mac_en && (taps_left == '0);

endmodule

// File: rtl/fir_datapath.sv
`timescale 1ns/1ps
module fir_datapath #(
  parameter int DW   = 16,
  parameter int CW   = 16,
  parameter int FRAC = 15,
  parameter int N    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_en,
  input  logic          mac_en,
  input  logic          last_tap,
  input  logic [DW-1:0] win_rd,
  input  logic [CW-1:0] coef_rd,
  output logic          out_valid,
  output logic [DW-1:0] out_data
);
  localparam int PW   = DW + CW - FRAC;
  localparam int GW   = (N > 1) ? $clog2(N) : 1;
  localparam int ACCW = PW + GW;
  localparam logic signed [ACCW-1:0] MAXV = {{(ACCW-DW+1){1'b0}}, {(DW-1){1'b1}}};
  localparam logic signed [ACCW-1:0] MINV = {{(ACCW-DW+1){1'b1}}, {(DW-1){1'b0}}};

  // product rescaled to the sample format (floor)
  function automatic logic signed [PW-1:0] scaled_product(
    input logic signed [DW-1:0] x, input logic signed [CW-1:0] c);
    logic signed [DW+CW-1:0] full;
    logic signed [DW+CW-1:0] shifted;
    full    = x * c;
    shifted = full >>> FRAC;
    return shifted[PW-1:0];
  endfunction

  function automatic logic [DW-1:0] saturate(input logic signed [ACCW-1:0] a);
    if (a > MAXV)      return MAXV[DW-1:0];
    else if (a < MINV) return MINV[DW-1:0];
    else               return a[DW-1:0];
  endfunction

  logic signed [DW-1:0]   op_x;
  logic signed [CW-1:0]   op_c;
  logic signed [ACCW-1:0] acc;
  logic signed [PW-1:0]   prod;
  logic signed [ACCW-1:0] sum_next;

  assign prod     = scaled_product(op_x, op_c);
  assign sum_next = acc + {{GW{prod[PW-1]}}, prod};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_x      <= '0;
      op_c      <= '0;
      acc       <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= 1'b0;
      if (load_en) begin
        op_x <= win_rd;
        op_c <= coef_rd;
        acc  <= '0;
      end else if (mac_en) begin
        acc  <= sum_next;
        op_x <= win_rd;
        op_c <= coef_rd;
        if (last_tap) begin
          out_data  <= saturate(sum_next);
          out_valid <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/fir_mac_engine.sv
`timescale 1ns/1ps
module fir_mac_engine #(
  parameter int DW   = 16,
  parameter int CW   = 16,
  parameter int FRAC = 15,
  parameter int N    = 8,
  localparam int AW  = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_valid,
  input  logic [DW-1:0] smp_data,
  input  logic          coef_we,
  input  logic [AW-1:0] coef_addr,
  input  logic [CW-1:0] coef_data,
  input  logic          start,
  output logic          busy,
  output logic          out_valid,
  output logic [DW-1:0] out_data
);
  // named internal events
  logic          smp_push;
  logic          coef_push;
  logic          load_en;
  logic          mac_en;
  logic          last_tap;
  logic [AW-1:0] head;
  logic [AW-1:0] newest;
  logic [AW-1:0] sptr;
  logic [AW-1:0] cptr;
  logic [DW-1:0] win_rd;
  logic [CW-1:0] coef_rd;

  logic [DW-1:0] win_mem  [N];
  logic [CW-1:0] coef_mem [N];

  assign smp_push  = smp_valid && !busy;
  assign coef_push = coef_we && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) win_mem[i] <= '0;
    end else if (smp_push) begin
      win_mem[head] <= smp_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) coef_mem[i] <= '0;
    end else if (coef_push) begin
      coef_mem[coef_addr] <= coef_data;
    end
  end

  assign win_rd  = win_mem[load_en ? newest : sptr];
  assign coef_rd = coef_mem[load_en ? AW'(0) : cptr];

  fir_agu #(.N(N), .AW(AW)) u_agu (
    .clk      (clk),
    .rst_n    (rst_n),
    .smp_push (smp_push),
    .load_en  (load_en),
    .mac_en   (mac_en),
    .head     (head),
    .newest   (newest),
    .sptr     (sptr),
    .cptr     (cptr)
  );

  fir_seq #(.N(N), .AW(AW)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .busy     (busy),
    .load_en  (load_en),
    .mac_en   (mac_en),
    .last_tap (last_tap)
  );

  fir_datapath #(.DW(DW), .CW(CW), .FRAC(FRAC), .N(N)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_en   (load_en),
    .mac_en    (mac_en),
    .last_tap  (last_tap),
    .win_rd    (win_rd),
    .coef_rd   (coef_rd),
    .out_valid (out_valid),
    .out_data  (out_data)
  );

endmodule

// File: rtl/fir_mac_engine_chk.sv
`timescale 1ns/1ps
module fir_mac_engine_chk #(
  parameter int N  = 8,
  parameter int AW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          smp_valid,
  input logic          busy,
  input logic          load_en,
  input logic          mac_en,
  input logic          last_tap,
  input logic          out_valid,
  input logic [AW-1:0] head
);

  a_r4_start_sets_up: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && load_en));

  a_r6_setup_then_mac: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> mac_en);

  a_r6_no_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (mac_en && !last_tap) |=> mac_en);

  a_r6_result_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    last_tap |=> (out_valid && !busy));

  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  a_r3_head_frozen_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(head));

  a_r3_head_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (N > 1 && smp_valid && !busy) |=> (head != $past(head)));

endmodule

bind fir_mac_engine fir_mac_engine_chk #(.N(N), .AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .smp_valid (smp_valid),
  .busy      (busy),
  .load_en   (load_en),
  .mac_en    (mac_en),
  .last_tap  (last_tap),
  .out_valid (out_valid),
  .head      (head)
);

// File: tb/fir_mac_engine_test.sv
`timescale 1ns/1ps
module fir_mac_engine_test;
  localparam int N    = 8;
  localparam int DW   = 16;
  localparam int CW   = 16;
  localparam int FRAC = 15;
  localparam int AW   = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          smp_valid = 1'b0;
  logic [DW-1:0] smp_data = '0;
  logic          coef_we = 1'b0;
  logic [AW-1:0] coef_addr = '0;
  logic [CW-1:0] coef_data = '0;
  logic          start = 1'b0;
  logic          busy;
  logic          out_valid;
  logic [DW-1:0] out_data;

  int checks = 0;
  int errors = 0;
  longint coef_m [N];
  longint hist_m [N];   // hist_m[0] is the newest sample

  fir_mac_engine #(.DW(DW), .CW(CW), .FRAC(FRAC), .N(N)) uut (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
    .coef_we(coef_we), .coef_addr(coef_addr), .coef_data(coef_data),
    .start(start), .busy(busy), .out_valid(out_valid), .out_data(out_data));

  always #5 clk = ~clk;

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: run hung, actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  function automatic longint floor_scale(longint x, longint c);
    longint p = x * c;
    longint d = longint'(1) << FRAC;
    if (p >= 0) return p / d;
    return -((-p + d - 1) / d);
  endfunction

  function automatic longint model_out();
    longint s = 0;
    longint hi = (longint'(1) << (DW - 1)) - 1;
    longint lo = -(longint'(1) << (DW - 1));
    for (int k = 0; k < N; k++) s += floor_scale(hist_m[k], coef_m[k]);
    if (s > hi) return hi;
    if (s < lo) return lo;
    return s;
  endfunction

  task automatic check(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push(longint v);
    @(negedge clk);
    smp_valid = 1'b1;
    smp_data  = DW'(v);
    @(negedge clk);
    smp_valid = 1'b0;
    for (int k = N - 1; k > 0; k--) hist_m[k] = hist_m[k-1];
    hist_m[0] = v;
  endtask

  task automatic wcoef(int a, longint v);
    @(negedge clk);
    coef_we   = 1'b1;
    coef_addr = AW'(a);
    coef_data = CW'(v);
    @(negedge clk);
    coef_we = 1'b0;
    coef_m[a] = v;
  endtask

  task automatic run(string req, bit disturb);
    longint exp = model_out();
    longint held;
    int cyc;
    int extra = 0;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    check(busy == 1'b1, "R4 busy after start", longint'(busy), 1);
    if (disturb) begin
      smp_valid = 1'b1; smp_data = 16'h1234;
      coef_we = 1'b1; coef_addr = '0; coef_data = 16'h4000;
      start = 1'b1;
    end
    while (!out_valid && cyc < N + 10) begin
      @(negedge clk);
      smp_valid = 1'b0; coef_we = 1'b0; start = 1'b0;
      cyc++;
    end
    check(cyc == N + 2, "R6 latency", cyc, N + 2);
    check(longint'($signed(out_data)) == exp, req, longint'($signed(out_data)), exp);
    held = longint'($signed(out_data));
    @(negedge clk);
    check(!out_valid && !busy, "R6 one-cycle pulse", longint'(out_valid), 0);
    check(longint'($signed(out_data)) == held, "R8 output held", longint'($signed(out_data)), held);
    if (disturb) begin
      for (int i = 0; i < N + 4; i++) begin
        @(negedge clk);
        if (out_valid) extra++;
      end
      check(extra == 0, "R4 start while busy ignored", extra, 0);
    end
  endtask

  initial begin
    void'($urandom(32'd7741));
    for (int k = 0; k < N; k++) begin coef_m[k] = 0; hist_m[k] = 0; end
    repeat (3) @(negedge clk);
    check(busy == 1'b0, "R1 busy after reset", longint'(busy), 0);
    check(out_valid == 1'b0, "R1 out_valid after reset", longint'(out_valid), 0);
    check(out_data == '0, "R1 out_data after reset", longint'(out_data), 0);
    rst_n = 1'b1;
    run("R1 empty memories give zero", 1'b0);

    // directed: distinct weights, impulse walks through the window
    for (int k = 0; k < N; k++) wcoef(k, 1000 * (k + 1));
    push(16384);
    run("R5 impulse newest", 1'b0);
    push(0);
    push(0);
    run("R5 impulse two steps old", 1'b0);
    for (int k = 0; k < 11; k++) push(100 * k - 300);
    run("R10 window after wrap", 1'b0);
    run("R9 repeat run same result", 1'b0);

    // R2 R3 R4: strobes during busy have no effect
    run("R2 R3 writes while busy ignored", 1'b1);
    run("R2 R3 state unchanged after busy writes", 1'b0);

    // R7 saturation both ways
    for (int k = 0; k < N; k++) wcoef(k, 32767);
    for (int k = 0; k < N; k++) push(32767);
    run("R7 positive saturation", 1'b0);
    for (int k = 0; k < N; k++) push(-32768);
    run("R7 negative saturation", 1'b0);
    wcoef(0, -32768);
    for (int k = 1; k < N; k++) wcoef(k, 0);
    run("R5 min times min", 1'b0);

    // constrained random
    for (int it = 0; it < 30; it++) begin
      int nc = int'($urandom_range(0, 2));
      int ns = int'($urandom_range(1, 3));
      for (int j = 0; j < nc; j++) begin
        longint v = longint'($signed(16'($urandom)));
        if ($urandom_range(0, 1) == 1) v = v / 8;
        wcoef(int'($urandom_range(0, N - 1)), v);
      end
      for (int j = 0; j < ns; j++) push(longint'($signed(16'($urandom))) / 4);
      run("R5 random mix", 1'b0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule